// File: doc/BRIEF.md
# Tagged Instruction Address Translation Cache

This block translates 48-bit instruction fetch addresses into 40-bit physical addresses for a core that runs two hardware threads. Translations for 4 KB pages sit in one set-associative array that both threads share. Translations for 2 MB and 4 MB pages sit in a small fully-associative group that belongs to one thread alone. Both structures are searched in parallel on every lookup. The result is registered, so it appears on the cycle after the request.

Each entry carries a virtual-machine tag and an address-space tag. A hit needs both tags to equal the ones presented with the lookup. This lets translations for different guests and processes live side by side, so a context switch needs no flush. When software does want entries removed, a command port drops every entry, the entries of one virtual machine, or the entries of one address space inside one virtual machine.

The page walker loads new translations through a fill port that states the page size. Victims are chosen by a not-recently-used scheme inside a set, or inside one thread's large-page group.

Top module: `itlb_top`

## Requirements
- R1: A 4 KB translation hits when a valid entry has the same VA[47:17], VMID and ASID in the set selected by VA[16:12]. The returned address is {stored PA[39:12], VA[11:0]}. The array has 32 sets of 4 ways.
- R2: 4 KB entries are shared: an entry filled while fill_tid is 0 hits for a lookup with req_tid 1, and the other way round.
- R3: An entry hits only when both its VMID and its ASID equal the lookup's. Entries for the same VA under different VMIDs coexist and each returns its own address.
- R4: fill_size encodes 0 = 4 KB, 1 = 2 MB, 2 = 4 MB; the value 3 writes nothing. A 2 MB entry matches on VA[47:21] and returns {PA[39:21], VA[20:0]}. A 4 MB entry matches on VA[47:22] and returns {PA[39:22], VA[21:0]}.
- R5: Each thread has 7 private large-page entries. A lookup only searches the requesting thread's group, and a fill only replaces entries in the filling thread's group.
- R6: The fill victim is the lowest-numbered invalid way. When every way is valid, the victim is the lowest-numbered way whose recently-used bit is clear. A hit or a fill sets the way's bit, and when that would set every bit, only that way's bit is left set.
- R7: rsp_hit and rsp_pa reflect the request presented one cycle earlier. A cycle without req_valid gives rsp_hit 0, and rsp_pa is 0 whenever rsp_hit is 0.
- R8: inv_kind encodes 0 = no action, 1 = drop all entries, 2 = drop entries whose VMID equals inv_vmid, 3 = drop entries whose VMID and ASID equal inv_vmid and inv_asid. The command covers both arrays and both threads. A fill in the same cycle as a command keeps its new entry.
- R9: Reset empties both arrays and clears rsp_hit and rsp_pa.
- R10: When the 4 KB array and the thread's large-page group both hit, the large-page translation is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_tid | input | 1 | Requesting thread |
| req_vmid | input | 8 | Virtual-machine tag of the lookup |
| req_asid | input | 12 | Address-space tag of the lookup |
| req_va | input | 48 | Virtual address to translate |
| fill_valid | input | 1 | Write one translation |
| fill_tid | input | 1 | Thread that owns a large-page fill |
| fill_vmid | input | 8 | Virtual-machine tag of the new entry |
| fill_asid | input | 12 | Address-space tag of the new entry |
| fill_va | input | 48 | Virtual address of the new entry |
| fill_pa | input | 40 | Physical address of the new entry |
| fill_size | input | 2 | Page size code |
| inv_valid | input | 1 | Invalidate command strobe |
| inv_kind | input | 2 | Invalidate scope code |
| inv_vmid | input | 8 | VMID selected by the command |
| inv_asid | input | 12 | ASID selected by the command |
| rsp_hit | output | 1 | Registered hit |
| rsp_pa | output | 40 | Registered physical address |

## Verification
The bench builds the block with its defaults: 2 threads, 32 sets of 4 ways, and 7 large entries per thread. With these values a single set fills up after four fills, which brings eviction by recently-used bits within reach. A thread's large-page group overflows on its eighth fill, so the bench can show that the other thread's entry survives. Translations that differ only in VMID or ASID, both large-page sizes at their offset boundaries, every invalidate scope, and a fill that coincides with a full invalidate are all exercised.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
    localparam int VA_W   = 48;
    localparam int PA_W   = 40;
    localparam int VMID_W = 8;
    localparam int ASID_W = 12;
    localparam int OFS_4K = 12;
    localparam int OFS_2M = 21;

    typedef enum logic [1:0] {PG_4K = 2'd0, PG_2M = 2'd1, PG_4M = 2'd2} pg_size_e;
    typedef enum logic [1:0] {INV_NONE = 2'd0, INV_ALL = 2'd1, INV_VM = 2'd2, INV_VM_AS = 2'd3} inv_kind_e;

    typedef struct packed {
        logic [VMID_W-1:0] vmid;
        logic [ASID_W-1:0] asid;
    } ctx_t;

    function automatic logic inv_hits(inv_kind_e kind, ctx_t ent, ctx_t cmd);
        case (kind)
            INV_ALL:   return 1'b1;
            INV_VM:    return ent.vmid == cmd.vmid;
            INV_VM_AS: return ent == cmd;
            default:   return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/itlb_victim.sv
module itlb_victim #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  valid,
    input  logic [N-1:0]  used,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] free_i, cold_i;
    logic          any_free;

    always_comb begin
        free_i   = '0;
        cold_i   = '0;
        any_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_i   = IW'(i);
                any_free = 1'b1;
            end
            if (!used[i]) cold_i = IW'(i);
        end
        idx = any_free ? free_i : cold_i;
    end
endmodule

// File: rtl/itlb_small.sv
module itlb_small
    import itlb_pkg::*;
#(
    parameter int SETS = 32,
    parameter int WAYS = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_valid,
    input  logic [VA_W-1:0] lk_va,
    input  ctx_t            lk_ctx,
    output logic            lk_hit,
    output logic [PA_W-1:0] lk_pa,
    input  logic            fl_valid,
    input  logic [VA_W-1:0] fl_va,
    input  ctx_t            fl_ctx,
    input  logic [PA_W-1:0] fl_pa,
    input  logic            inv_valid,
    input  inv_kind_e       inv_kind,
    input  ctx_t            inv_ctx
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VA_W - OFS_4K - IDX_W;
    localparam int PPN_W = PA_W - OFS_4K;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [WAYS-1:0]  vld  [SETS];
    logic [WAYS-1:0]  used [SETS];
    logic [TAG_W-1:0] tag  [SETS][WAYS];
    ctx_t             ctx  [SETS][WAYS];
    logic [PPN_W-1:0] ppn  [SETS][WAYS];

    logic [IDX_W-1:0] ridx, fidx;
    logic [WAYS-1:0]  hitv;
    logic [WAY_W-1:0] sel, vic;

    assign ridx = lk_va[OFS_4K +: IDX_W];
    assign fidx = fl_va[OFS_4K +: IDX_W];

    function automatic logic [WAYS-1:0] touch(logic [WAYS-1:0] u, logic [WAY_W-1:0] w);
        logic [WAYS-1:0] hot, t;
        hot = WAYS'(1) << w;
        t   = u | hot;
        return (&t) ? hot : t;
    endfunction

    always_comb begin
        lk_hit = 1'b0;
        sel    = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            hitv[w] = vld[ridx][w] && tag[ridx][w] == lk_va[VA_W-1 -: TAG_W]
                      && ctx[ridx][w] == lk_ctx;
            if (hitv[w]) begin
                sel    = WAY_W'(w);
                lk_hit = 1'b1;
            end
        end
        lk_pa = {ppn[ridx][sel], lk_va[OFS_4K-1:0]};
    end

    itlb_victim #(.N(WAYS)) u_vic (.valid(vld[fidx]), .used(used[fidx]), .idx(vic));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                vld[s]  <= '0;
                used[s] <= '0;
            end
        end else begin
            if (inv_valid) begin
                for (int s = 0; s < SETS; s++)
                    for (int w = 0; w < WAYS; w++)
                        if (inv_hits(inv_kind, ctx[s][w], inv_ctx)) vld[s][w] <= 1'b0;
            end
            if (lk_valid && lk_hit) used[ridx] <= touch(used[ridx], sel);
            if (fl_valid) begin
                vld[fidx][vic] <= 1'b1;
                used[fidx]     <= touch(used[fidx], vic);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fl_valid) begin
            tag[fidx][vic] <= fl_va[VA_W-1 -: TAG_W];
            ctx[fidx][vic] <= fl_ctx;
            ppn[fidx][vic] <= fl_pa[PA_W-1:OFS_4K];
        end
    end
endmodule

// File: rtl/itlb_large.sv
module itlb_large
    import itlb_pkg::*;
#(
    parameter int ENTRIES = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_valid,
    input  logic [VA_W-1:0] lk_va,
    input  ctx_t            lk_ctx,
    output logic            lk_hit,
    output logic [PA_W-1:0] lk_pa,
    input  logic            fl_valid,
    input  logic            fl_big,
    input  logic [VA_W-1:0] fl_va,
    input  ctx_t            fl_ctx,
    input  logic [PA_W-1:0] fl_pa,
    input  logic            inv_valid,
    input  inv_kind_e       inv_kind,
    input  ctx_t            inv_ctx
);
    localparam int VPN_W = VA_W - OFS_2M;
    localparam int PPN_W = PA_W - OFS_2M;
    localparam int EW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld, used, big;
    logic [VPN_W-1:0]   vpn [ENTRIES];
    logic [PPN_W-1:0]   ppn [ENTRIES];
    ctx_t               ctx [ENTRIES];

    logic [EW-1:0] sel, vic;

    function automatic logic [ENTRIES-1:0] touch(logic [ENTRIES-1:0] u, logic [EW-1:0] e);
        logic [ENTRIES-1:0] hot, t;
        hot = ENTRIES'(1) << e;
        t   = u | hot;
        return (&t) ? hot : t;
    endfunction

    always_comb begin
        lk_hit = 1'b0;
        sel    = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (vld[e] && ctx[e] == lk_ctx
                && vpn[e][VPN_W-1:1] == lk_va[VA_W-1:OFS_2M+1]
                && (big[e] || vpn[e][0] == lk_va[OFS_2M])) begin
                sel    = EW'(e);
                lk_hit = 1'b1;
            end
        end
        if (big[sel]) lk_pa = {ppn[sel][PPN_W-1:1], lk_va[OFS_2M:0]};
        else          lk_pa = {ppn[sel], lk_va[OFS_2M-1:0]};
    end

    itlb_victim #(.N(ENTRIES)) u_vic (.valid(vld), .used(used), .idx(vic));

    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= '0;
            used <= '0;
        end else begin
            if (inv_valid) begin
                for (int e = 0; e < ENTRIES; e++)
                    if (inv_hits(inv_kind, ctx[e], inv_ctx)) vld[e] <= 1'b0;
            end
            if (lk_valid && lk_hit) used <= touch(used, sel);
            if (fl_valid) begin
                vld[vic] <= 1'b1;
                used     <= touch(used, vic);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fl_valid) begin
            big[vic] <= fl_big;
            vpn[vic] <= fl_va[VA_W-1:OFS_2M];
            ppn[vic] <= fl_pa[PA_W-1:OFS_2M];
            ctx[vic] <= fl_ctx;
        end
    end
endmodule

// File: rtl/itlb_top.sv
module itlb_top
    import itlb_pkg::*;
#(
    parameter int THREADS   = 2,
    parameter int SETS      = 32,
    parameter int WAYS      = 4,
    parameter int LG_PER_TH = 7,
    localparam int TID_W    = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [TID_W-1:0]  req_tid,
    input  logic [VMID_W-1:0] req_vmid,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [VA_W-1:0]   req_va,
    input  logic              fill_valid,
    input  logic [TID_W-1:0]  fill_tid,
    input  logic [VMID_W-1:0] fill_vmid,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VA_W-1:0]   fill_va,
    input  logic [PA_W-1:0]   fill_pa,
    input  logic [1:0]        fill_size,
    input  logic              inv_valid,
    input  logic [1:0]        inv_kind,
    input  logic [VMID_W-1:0] inv_vmid,
    input  logic [ASID_W-1:0] inv_asid,
    output logic              rsp_hit,
    output logic [PA_W-1:0]   rsp_pa
);
    ctx_t      req_ctx, fill_ctx, inv_ctx;
    pg_size_e  fsz;
    inv_kind_e ikind;
    logic      fill_small, fill_large;

    assign req_ctx    = '{vmid: req_vmid, asid: req_asid};
    assign fill_ctx   = '{vmid: fill_vmid, asid: fill_asid};
    assign inv_ctx    = '{vmid: inv_vmid, asid: inv_asid};
    assign fsz        = pg_size_e'(fill_size);
    assign ikind      = inv_kind_e'(inv_kind);
    assign fill_small = fill_valid && fsz == PG_4K;
    assign fill_large = fill_valid && (fsz == PG_2M || fsz == PG_4M);

    logic            sm_hit;
    logic [PA_W-1:0] sm_pa;
    logic            lg_hit [THREADS];
    logic [PA_W-1:0] lg_pa  [THREADS];

    itlb_small #(.SETS(SETS), .WAYS(WAYS)) u_small (
        .clk(clk), .rst(rst),
        .lk_valid(req_valid), .lk_va(req_va), .lk_ctx(req_ctx),
        .lk_hit(sm_hit), .lk_pa(sm_pa),
        .fl_valid(fill_small), .fl_va(fill_va), .fl_ctx(fill_ctx), .fl_pa(fill_pa),
        .inv_valid(inv_valid), .inv_kind(ikind), .inv_ctx(inv_ctx)
    );

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        itlb_large #(.ENTRIES(LG_PER_TH)) u_large (
            .clk(clk), .rst(rst),
            .lk_valid(req_valid && req_tid == TID_W'(t)), .lk_va(req_va), .lk_ctx(req_ctx),
            .lk_hit(lg_hit[t]), .lk_pa(lg_pa[t]),
            .fl_valid(fill_large && fill_tid == TID_W'(t)), .fl_big(fsz == PG_4M),
            .fl_va(fill_va), .fl_ctx(fill_ctx), .fl_pa(fill_pa),
            .inv_valid(inv_valid), .inv_kind(ikind), .inv_ctx(inv_ctx)
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_hit <= 1'b0;
            rsp_pa  <= '0;
        end else begin
            rsp_hit <= req_valid && (sm_hit || lg_hit[req_tid]);
            if (!req_valid)           rsp_pa <= '0;
            else if (lg_hit[req_tid]) rsp_pa <= lg_pa[req_tid];
            else if (sm_hit)          rsp_pa <= sm_pa;
            else                      rsp_pa <= '0;
        end
    end
endmodule

// File: rtl/itlb_chk.sv
module itlb_chk
    import itlb_pkg::*;
#(
    parameter int TID_W = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [TID_W-1:0]  req_tid,
    input logic [VMID_W-1:0] req_vmid,
    input logic [ASID_W-1:0] req_asid,
    input logic [VA_W-1:0]   req_va,
    input logic              fill_valid,
    input logic [TID_W-1:0]  fill_tid,
    input logic [VMID_W-1:0] fill_vmid,
    input logic [ASID_W-1:0] fill_asid,
    input logic [VA_W-1:0]   fill_va,
    input logic [PA_W-1:0]   fill_pa,
    input logic [1:0]        fill_size,
    input logic              inv_valid,
    input logic [1:0]        inv_kind,
    input logic [VMID_W-1:0] inv_vmid,
    input logic [ASID_W-1:0] inv_asid,
    input logic              rsp_hit,
    input logic [PA_W-1:0]   rsp_pa
);
    a_r7_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_hit);

    a_r1_offset_kept: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!rsp_hit || rsp_pa[OFS_4K-1:0] == $past(req_va[OFS_4K-1:0])));

    a_r8_flush_all: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && inv_kind == 2'd1 && !fill_valid) |-> ##2 !rsp_hit);

    a_r9_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_hit && rsp_pa == '0));
endmodule

bind itlb_top itlb_chk #(.TID_W(TID_W)) u_chk (.*);

// File: tb/sim_itlb_top.sv
module sim_itlb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, fill_valid, inv_valid;
    logic [0:0]  req_tid, fill_tid;
    logic [7:0]  req_vmid, fill_vmid, inv_vmid;
    logic [11:0] req_asid, fill_asid, inv_asid;
    logic [47:0] req_va, fill_va;
    logic [39:0] fill_pa, rsp_pa;
    logic [1:0]  fill_size, inv_kind;
    logic        rsp_hit;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    itlb_top u0 (.*);

    typedef struct packed {
        logic [1:0]  op;
        logic        tid;
        logic [7:0]  vm;
        logic [11:0] as;
        logic [47:0] va;
        logic [39:0] pa;
        logic [1:0]  sz;
        logic [3:0]  rq;
        logic        eh;
        logic [39:0] epa;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{2'd1,1'b0,8'd1,12'd5,48'h0000_1234_5000,40'h00_8765_4000,2'd0,4'd1,1'b0,40'h0},           // fill 4K
        '{2'd0,1'b0,8'd1,12'd5,48'h0000_1234_5ABC,40'h0,2'd0,4'd1,1'b1,40'h00_8765_4ABC},           // R1
        '{2'd0,1'b1,8'd1,12'd5,48'h0000_1234_5ABC,40'h0,2'd0,4'd2,1'b1,40'h00_8765_4ABC},           // R2
        '{2'd0,1'b0,8'd1,12'd6,48'h0000_1234_5ABC,40'h0,2'd0,4'd3,1'b0,40'h0},                      // R3 asid
        '{2'd0,1'b0,8'd2,12'd5,48'h0000_1234_5ABC,40'h0,2'd0,4'd3,1'b0,40'h0},                      // R3 vmid
        '{2'd1,1'b0,8'd1,12'd5,48'h0000_4020_0000,40'h01_2340_0000,2'd1,4'd4,1'b0,40'h0},           // fill 2M
        '{2'd0,1'b0,8'd1,12'd5,48'h0000_403F_FFF0,40'h0,2'd0,4'd4,1'b1,40'h01_235F_FFF0},           // R4
        '{2'd0,1'b0,8'd1,12'd5,48'h0000_4040_0000,40'h0,2'd0,4'd4,1'b0,40'h0},                      // R4 next 2M
        '{2'd0,1'b1,8'd1,12'd5,48'h0000_403F_FFF0,40'h0,2'd0,4'd5,1'b0,40'h0},                      // R5 private
        '{2'd1,1'b1,8'd1,12'd5,48'h0000_8000_0000,40'h02_0000_0000,2'd2,4'd4,1'b0,40'h0},           // fill 4M
        '{2'd0,1'b1,8'd1,12'd5,48'h0000_803F_FFFC,40'h0,2'd0,4'd4,1'b1,40'h02_003F_FFFC},           // R4 4M
        '{2'd1,1'b0,8'd4,12'd4,48'h0000_0077_7000,40'h00_0999_9000,2'd3,4'd4,1'b0,40'h0},           // size 3
        '{2'd0,1'b0,8'd4,12'd4,48'h0000_0077_7000,40'h0,2'd0,4'd4,1'b0,40'h0},                      // R4 no write
        '{2'd2,1'b0,8'd1,12'd6,48'h0,40'h0,2'd3,4'd8,1'b0,40'h0},                                   // inv vm1/as6
        '{2'd0,1'b0,8'd1,12'd5,48'h0000_1234_5ABC,40'h0,2'd0,4'd8,1'b1,40'h00_8765_4ABC},           // R8 survives
        '{2'd1,1'b0,8'd2,12'd5,48'h0000_1234_5000,40'h00_1111_1000,2'd0,4'd3,1'b0,40'h0},           // fill vm2
        '{2'd0,1'b0,8'd2,12'd5,48'h0000_1234_5010,40'h0,2'd0,4'd3,1'b1,40'h00_1111_1010},           // R3
        '{2'd0,1'b0,8'd1,12'd5,48'h0000_1234_5010,40'h0,2'd0,4'd3,1'b1,40'h00_8765_4010},           // R3
        '{2'd2,1'b0,8'd1,12'd0,48'h0,40'h0,2'd2,4'd8,1'b0,40'h0},                                   // inv vm1
        '{2'd0,1'b0,8'd1,12'd5,48'h0000_1234_5010,40'h0,2'd0,4'd8,1'b0,40'h0},                      // R8
        '{2'd0,1'b0,8'd2,12'd5,48'h0000_1234_5010,40'h0,2'd0,4'd8,1'b1,40'h00_1111_1010},           // R8
        '{2'd0,1'b1,8'd1,12'd5,48'h0000_803F_FFFC,40'h0,2'd0,4'd8,1'b0,40'h0},                      // R8 large
        '{2'd2,1'b0,8'd2,12'd5,48'h0,40'h0,2'd3,4'd8,1'b0,40'h0},                                   // inv vm2/as5
        '{2'd0,1'b0,8'd2,12'd5,48'h0000_1234_5010,40'h0,2'd0,4'd8,1'b0,40'h0},                      // R8
        '{2'd1,1'b1,8'd9,12'd0,48'h0000_0000_3000,40'h00_0000_9000,2'd0,4'd8,1'b0,40'h0},           // fill vm9
        '{2'd2,1'b0,8'd0,12'd0,48'h0,40'h0,2'd1,4'd8,1'b0,40'h0},                                   // inv all
        '{2'd0,1'b0,8'd9,12'd0,48'h0000_0000_3004,40'h0,2'd0,4'd8,1'b0,40'h0}                       // R8 all
    };

    task automatic idle();
        req_valid = 0; fill_valid = 0; inv_valid = 0;
        req_tid = 0; fill_tid = 0; req_vmid = 0; fill_vmid = 0; inv_vmid = 0;
        req_asid = 0; fill_asid = 0; inv_asid = 0; req_va = 0; fill_va = 0;
        fill_pa = 0; fill_size = 0; inv_kind = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string rq, logic eh, logic [39:0] epa);
        n_chk++;
        if (rsp_hit !== eh || rsp_pa !== epa) begin
            n_fail++;
            $display("FAIL %s: hit=%0b pa=%h expected hit=%0b pa=%h", rq, rsp_hit, rsp_pa, eh, epa);
        end
    endtask

    task automatic fill(logic t, logic [7:0] vm, logic [11:0] as, logic [47:0] va,
                        logic [39:0] pa, logic [1:0] sz);
        fill_valid = 1; fill_tid = t; fill_vmid = vm; fill_asid = as;
        fill_va = va; fill_pa = pa; fill_size = sz;
        tick();
        fill_valid = 0;
    endtask

    task automatic look(string rq, logic t, logic [7:0] vm, logic [11:0] as, logic [47:0] va,
                        logic eh, logic [39:0] epa);
        req_valid = 1; req_tid = t; req_vmid = vm; req_asid = as; req_va = va;
        tick();
        req_valid = 0;
        check(rq, eh, epa);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        tick(); tick();
        rst = 0;
        check("R9", 1'b0, 40'h0);          // reset state
        tick();
        check("R7", 1'b0, 40'h0);          // no request, no hit

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string rq;
            v = VECS[i];
            rq = $sformatf("R%0d", v.rq);
            case (v.op)
                2'd0: look(rq, v.tid, v.vm, v.as, v.va, v.eh, v.epa);
                2'd1: fill(v.tid, v.vm, v.as, v.va, v.pa, v.sz);
                default: begin
                    inv_valid = 1; inv_kind = v.sz; inv_vmid = v.vm; inv_asid = v.as;
                    tick();
                    inv_valid = 0;
                end
            endcase
        end

        // R6: set 5, fill four ways, touch way 0, fifth fill evicts way 1
        for (int k = 0; k < 4; k++)
            fill(1'b0, 8'd3, 12'd1, 48'h0000_0100_5000 + (48'(k) << 20), 40'h10_0000_0000 | (40'(k) << 16), 2'd0);
        look("R6", 1'b1, 8'd3, 12'd1, 48'h0000_0100_5000, 1'b1, 40'h10_0000_0000);
        fill(1'b1, 8'd3, 12'd1, 48'h0000_0140_5000, 40'h10_0004_0000, 2'd0);
        look("R6", 1'b0, 8'd3, 12'd1, 48'h0000_0110_5000, 1'b0, 40'h0);
        look("R6", 1'b0, 8'd3, 12'd1, 48'h0000_0100_5008, 1'b1, 40'h10_0000_0008);
        look("R6", 1'b0, 8'd3, 12'd1, 48'h0000_0140_5008, 1'b1, 40'h10_0004_0008);
        look("R6", 1'b0, 8'd3, 12'd1, 48'h0000_0130_5000, 1'b1, 40'h10_0003_0000);

        // R5: thread 1 entry survives thread 0 overflowing its group
        fill(1'b1, 8'd3, 12'd1, 48'h0002_0000_0000, 40'h55_0000_0000, 2'd1);
        for (int k = 0; k < 8; k++)
            fill(1'b0, 8'd3, 12'd1, 48'h0001_0000_0000 + (48'(k) << 21), 40'h40_0000_0000 + (40'(k) << 21), 2'd1);
        look("R5", 1'b0, 8'd3, 12'd1, 48'h0001_0000_0010, 1'b0, 40'h0);
        look("R5", 1'b0, 8'd3, 12'd1, 48'h0001_00E0_0010, 1'b1, 40'h40_00E0_0010);
        look("R5", 1'b0, 8'd3, 12'd1, 48'h0001_0020_0010, 1'b1, 40'h40_0020_0010);
        look("R5", 1'b1, 8'd3, 12'd1, 48'h0002_0000_0040, 1'b1, 40'h55_0000_0040);

        // R10: same VA in both arrays
        fill(1'b0, 8'd3, 12'd1, 48'h0002_0000_0000, 40'h00_7777_7000, 2'd0);
        look("R10", 1'b1, 8'd3, 12'd1, 48'h0002_0000_0123, 1'b1, 40'h55_0000_0123);
        look("R2", 1'b0, 8'd3, 12'd1, 48'h0002_0000_0123, 1'b1, 40'h00_7777_7123);

        // R8: flush and fill in one cycle, new entry kept
        fill_valid = 1; fill_tid = 0; fill_vmid = 8'd3; fill_asid = 12'd1;
        fill_va = 48'h0003_0000_0000; fill_pa = 40'h00_3333_3000; fill_size = 2'd0;
        inv_valid = 1; inv_kind = 2'd1;
        tick();
        fill_valid = 0; inv_valid = 0;
        look("R8", 1'b0, 8'd3, 12'd1, 48'h0003_0000_0044, 1'b1, 40'h00_3333_3044);
        look("R8", 1'b1, 8'd3, 12'd1, 48'h0002_0000_0123, 1'b0, 40'h0);

        // R9: reset empties the arrays
        fill(1'b0, 8'd3, 12'd1, 48'h0004_0000_0000, 40'h00_4444_4000, 2'd0);
        rst = 1;
        tick(); tick();
        rst = 0;
        look("R9", 1'b0, 8'd3, 12'd1, 48'h0004_0000_0000, 1'b0, 40'h0);
        look("R9", 1'b0, 8'd3, 12'd1, 48'h0003_0000_0000, 1'b0, 40'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule